// File: doc/BRIEF.md
# Multi-Mode Link Test Pattern Generator

This block produces one 32-bit test word per clock for exercising a serial link. A 3-bit mode input chooses among eight patterns. There is a rotating sparse-ones word, a binary counter, an alternating checkerboard, a 32-bit pseudo-random sequence, an inverting (Johnson-style) shifter, a 24-bit pseudo-random sequence under a zero byte, a split counter word and a constant all-ones word. All eight generators run side by side, so switching the mode shows the chosen generator's current state on the next edge.

A second output carries a narrower 28-bit test word that stands in for normal trigger data. Its upper four bits are zero. Its lower 24 bits are either a fixed word supplied at the input or the 24-bit pseudo-random sequence, chosen by a select input. The generators step only while the enable input is high. Both outputs are registered. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `tpg_pattern_gen`

## Requirements
- R1: While reset is low, both outputs read zero. After reset the generators hold their seeds: rotator 0x01010101, shifter 0, both pseudo-random registers 0, all counters 0, and the checkerboard phase showing 0xAAAAAAAA first.
- R2: Both outputs are registered. The value after an edge comes from the inputs and the generator state sampled at that edge. Every generator advances by exactly one step on each edge where enable is 1, and holds on edges where enable is 0.
- R3: Mode 0 outputs a word with exactly four 1 bits, evenly spaced. The word rotates left by one position per step, so bit 31 wraps to bit 0.
- R4: Mode 1 outputs a 32-bit up counter that increments by one per step and wraps modulo 2^32.
- R5: Mode 2 alternates 0xAAAAAAAA and 0x55555555 on successive steps.
- R6: Mode 3 outputs a 32-bit shift-left register. Its new bit 0 is NOT(b31 XOR b21 XOR b1 XOR b0).
- R7: Mode 4 outputs a 32-bit register that shifts left each step. Its new bit 0 is the inverse of the old bit 31, so from zero it fills with ones and then with zeros.
- R8: Mode 5 outputs zero in bits 31..24 and the 24-bit pseudo-random register in bits 23..0. That register shifts left and takes NOT(b23 XOR b22 XOR b21 XOR b16) as its new bit 0.
- R9: Mode 6 outputs zero in bits 31..27, a 3-bit counter in bits 26..24 and a 24-bit counter in bits 23..0. Both counters increment on every step and wrap independently.
- R10: Mode 7 outputs 0xFFFFFFFF.
- R11: On every edge, whether or not enable is high, the 28-bit output loads zero in bits 27..24. Its bits 23..0 load the fixed word when the select is 0, and the 24-bit pseudo-random register when the select is 1.
- R12: Mode changes take effect on the next edge and do not disturb any generator's sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Steps all generators when high |
| mode | input | 3 | Pattern selection, 0 to 7 |
| fixed_word | input | 24 | Fixed test word for the 28-bit output |
| rand_sel | input | 1 | 1 selects the pseudo-random source for the 28-bit output |
| pattern_out | output | 32 | Registered 32-bit pattern word |
| test_word_out | output | 28 | Registered 28-bit test word |

## Verification
Each output is due one edge after the mode, enable, select and fixed word that produced it are sampled. A generator step taken on that same edge shows up only on the following edge. The scoreboard driver changes the inputs 2 ns after an edge. It records the expected words for the coming edge from a reference state that has not yet taken the step, and then steps that reference. The monitor compares 1 ns after each edge. After reset is released, the bench waits out the two synchronizer edges before it drives, and it checks the outputs immediately after reset is asserted.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

  typedef enum logic [2:0] {
    MODE_WALK    = 3'd0,
    MODE_COUNT   = 3'd1,
    MODE_CHECKER = 3'd2,
    MODE_PRBS_W  = 3'd3,
    MODE_JOHNSON = 3'd4,
    MODE_PRBS_N  = 3'd5,
    MODE_SPLIT   = 3'd6,
    MODE_ONES    = 3'd7
  } tpg_mode_e;

  // Tap masks: a set bit joins the feedback parity.
  localparam logic [31:0] TAPS_WIDE   = 32'h8020_0003; // bits 31,21,1,0
  localparam logic [23:0] TAPS_NARROW = 24'hE1_0000;   // bits 23,22,21,16

endpackage

// File: rtl/tpg_rst_sync.sv
module tpg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
  parameter int              W      = 24,
  parameter logic [W-1:0]    TAPS   = '0,
  parameter bit              INVERT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         parity;

  always_comb begin
    parity = ^(state_q & TAPS);
    state_d = state_q;
    if (adv) begin
      if (INVERT) state_d = {state_q[W-2:0], ~parity};
      else        state_d = {state_q[W-2:0], parity};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/tpg_shift_gens.sv
module tpg_shift_gens #(
  parameter int W     = 32,
  parameter int NONES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] rot,
  output logic         phase,
  output logic [W-1:0] john
);
  localparam int SPACING = W / NONES;

  function automatic logic [W-1:0] spaced_seed();
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = ((i % SPACING) == 0);
    return r;
  endfunction

  localparam logic [W-1:0] ROT_SEED = spaced_seed();

  logic [W-1:0] rot_q, rot_d;
  logic         phase_q, phase_d;
  logic [W-1:0] john_q, john_d;

  always_comb begin
    rot_d   = rot_q;
    phase_d = phase_q;
    john_d  = john_q;
    if (adv) begin
      rot_d   = {rot_q[W-2:0], rot_q[W-1]};
      phase_d = ~phase_q;
      john_d  = {john_q[W-2:0], ~john_q[W-1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rot_q   <= ROT_SEED;
      phase_q <= 1'b0;
      john_q  <= '0;
    end else begin
      rot_q   <= rot_d;
      phase_q <= phase_d;
      john_q  <= john_d;
    end
  end

  assign rot   = rot_q;
  assign phase = phase_q;
  assign john  = john_q;
endmodule

// File: rtl/tpg_count_gens.sv
module tpg_count_gens #(
  parameter int W    = 32,
  parameter int LO_W = 24,
  parameter int HI_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            adv,
  output logic [W-1:0]    full_cnt,
  output logic [LO_W-1:0] lo_cnt,
  output logic [HI_W-1:0] hi_cnt
);
  logic [W-1:0]    full_q, full_d;
  logic [LO_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0] hi_q, hi_d;

  always_comb begin
    full_d = full_q;
    lo_d   = lo_q;
    hi_d   = hi_q;
    if (adv) begin
      full_d = full_q + 1'b1;
      lo_d   = lo_q + 1'b1;
      hi_d   = hi_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      full_q <= full_d;
      lo_q   <= lo_d;
      hi_q   <= hi_d;
    end
  end

  assign full_cnt = full_q;
  assign lo_cnt   = lo_q;
  assign hi_cnt   = hi_q;
endmodule

// File: rtl/tpg_out_stage.sv
module tpg_out_stage
  import tpg_pkg::*;
#(
  parameter int W      = 32,
  parameter int RND_W  = 24,
  parameter int HI_W   = 3,
  parameter int TEST_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode,
  input  logic [W-1:0]      rot,
  input  logic              phase,
  input  logic [W-1:0]      john,
  input  logic [W-1:0]      prbs_w,
  input  logic [RND_W-1:0]  prbs_n,
  input  logic [W-1:0]      full_cnt,
  input  logic [RND_W-1:0]  lo_cnt,
  input  logic [HI_W-1:0]   hi_cnt,
  input  logic [RND_W-1:0]  fixed_word,
  input  logic              rand_sel,
  output logic [W-1:0]      pattern,
  output logic [TEST_W-1:0] test_word
);
  localparam int RND_PAD   = W - RND_W;
  localparam int SPLIT_PAD = W - RND_W - HI_W;
  localparam int TEST_PAD  = TEST_W - RND_W;
  localparam logic [W-1:0] CHK_A = {(W/2){2'b10}};

  logic [W-1:0]      pattern_q, pattern_d;
  logic [TEST_W-1:0] test_q, test_d;
  tpg_mode_e         sel;

  always_comb begin
    sel = tpg_mode_e'(mode);
    unique case (sel)
      MODE_WALK:    pattern_d = rot;
      MODE_COUNT:   pattern_d = full_cnt;
      MODE_CHECKER: pattern_d = phase ? ~CHK_A : CHK_A;
      MODE_PRBS_W:  pattern_d = prbs_w;
      MODE_JOHNSON: pattern_d = john;
      MODE_PRBS_N:  pattern_d = {{RND_PAD{1'b0}}, prbs_n};
      MODE_SPLIT:   pattern_d = {{SPLIT_PAD{1'b0}}, hi_cnt, lo_cnt};
      MODE_ONES:    pattern_d = '1;
      default:      pattern_d = '0;
    endcase
    test_d = {{TEST_PAD{1'b0}}, (rand_sel ? prbs_n : fixed_word)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pattern_q <= '0;
      test_q    <= '0;
    end else begin
      pattern_q <= pattern_d;
      test_q    <= test_d;
    end
  end

  assign pattern   = pattern_q;
  assign test_word = test_q;
endmodule

// File: rtl/tpg_pattern_gen.sv
module tpg_pattern_gen
  import tpg_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int RND_W  = 24,
  parameter int HI_W   = 3,
  parameter int TEST_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [2:0]        mode,
  input  logic [RND_W-1:0]  fixed_word,
  input  logic              rand_sel,
  output logic [WORD_W-1:0] pattern_out,
  output logic [TEST_W-1:0] test_word_out
);
  logic              rst_sync_n;
  logic [WORD_W-1:0] rot, john, prbs_w, full_cnt;
  logic              phase;
  logic [RND_W-1:0]  prbs_n, lo_cnt;
  logic [HI_W-1:0]   hi_cnt;

  tpg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  tpg_shift_gens #(.W(WORD_W), .NONES(4)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .adv(enable),
    .rot(rot), .phase(phase), .john(john)
  );

  tpg_lfsr #(.W(WORD_W), .TAPS(TAPS_WIDE), .INVERT(1'b1)) u_prbs_w (
    .clk(clk), .rst_n(rst_sync_n), .adv(enable), .state(prbs_w)
  );

  tpg_lfsr #(.W(RND_W), .TAPS(TAPS_NARROW), .INVERT(1'b1)) u_prbs_n (
    .clk(clk), .rst_n(rst_sync_n), .adv(enable), .state(prbs_n)
  );

  tpg_count_gens #(.W(WORD_W), .LO_W(RND_W), .HI_W(HI_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .adv(enable),
    .full_cnt(full_cnt), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt)
  );

  tpg_out_stage #(.W(WORD_W), .RND_W(RND_W), .HI_W(HI_W), .TEST_W(TEST_W)) u_out (
    .clk(clk), .rst_n(rst_sync_n), .mode(mode),
    .rot(rot), .phase(phase), .john(john), .prbs_w(prbs_w), .prbs_n(prbs_n),
    .full_cnt(full_cnt), .lo_cnt(lo_cnt), .hi_cnt(hi_cnt),
    .fixed_word(fixed_word), .rand_sel(rand_sel),
    .pattern(pattern_out), .test_word(test_word_out)
  );
endmodule

// File: rtl/tpg_pattern_gen_chk.sv
module tpg_pattern_gen_chk #(
  parameter int WORD_W = 32,
  parameter int RND_W  = 24,
  parameter int TEST_W = 28
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              enable,
  input logic [2:0]        mode,
  input logic [RND_W-1:0]  fixed_word,
  input logic              rand_sel,
  input logic [WORD_W-1:0] pattern_out,
  input logic [TEST_W-1:0] test_word_out
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  assert_walk_four_ones_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == 3'd0) |=> ($countones(pattern_out) == 4));

  assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (seen_q && mode == 3'd1 && $past(mode) == 3'd1 && $past(enable))
      |=> (pattern_out == $past(pattern_out) + 32'd1));

  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (seen_q && !$past(enable) && mode == $past(mode)) |=> $stable(pattern_out));

  assert_narrow_prbs_pad_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == 3'd5) |=> (pattern_out[WORD_W-1:RND_W] == '0));

  assert_split_pad_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == 3'd6) |=> (pattern_out[WORD_W-1:RND_W+3] == '0));

  assert_all_ones_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == 3'd7) |=> (pattern_out == '1));

  assert_fixed_pass_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (!rand_sel) |=> (test_word_out[RND_W-1:0] == $past(fixed_word)));

  assert_test_pad_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    seen_q |-> (test_word_out[TEST_W-1:RND_W] == '0));
endmodule

bind tpg_pattern_gen tpg_pattern_gen_chk #(
  .WORD_W(WORD_W), .RND_W(RND_W), .TEST_W(TEST_W)
) u_chk (
  .clk(clk), .rst_ni(rst_sync_n), .enable(enable), .mode(mode),
  .fixed_word(fixed_word), .rand_sel(rand_sel),
  .pattern_out(pattern_out), .test_word_out(test_word_out)
);

// File: tb/sim_tpg_pattern_gen.sv
module sim_tpg_pattern_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [2:0]  mode;
  logic [23:0] fixed_word;
  logic        rand_sel;
  logic [31:0] pattern_out;
  logic [27:0] test_word_out;

  always #4 clk = ~clk;

  tpg_pattern_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .fixed_word(fixed_word), .rand_sel(rand_sel),
    .pattern_out(pattern_out), .test_word_out(test_word_out)
  );

  typedef struct {
    logic [31:0] p;
    logic [27:0] t;
    string       tag;
  } item_t;

  item_t sb[$];
  item_t got;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference generator state
  logic [31:0] m_rot, m_cnt, m_l32, m_sh;
  logic        m_ph;
  logic [23:0] m_l24, m_c24;
  logic [2:0]  m_c3;

  task automatic model_reset();
    m_rot = 32'h0101_0101; m_cnt = '0; m_l32 = '0; m_sh = '0;
    m_ph = 1'b0; m_l24 = '0; m_c24 = '0; m_c3 = '0;
  endtask

  task automatic model_step();
    m_rot = {m_rot[30:0], m_rot[31]};
    m_cnt = m_cnt + 32'd1;
    m_ph  = ~m_ph;
    m_l32 = {m_l32[30:0], ~(m_l32[31] ^ m_l32[21] ^ m_l32[1] ^ m_l32[0])};
    m_sh  = {m_sh[30:0], ~m_sh[31]};
    m_l24 = {m_l24[22:0], ~(m_l24[23] ^ m_l24[22] ^ m_l24[21] ^ m_l24[16])};
    m_c24 = m_c24 + 24'd1;
    m_c3  = m_c3 + 3'd1;
  endtask

  function automatic logic [31:0] pick(input logic [2:0] m);
    case (m)
      3'd0: return m_rot;
      3'd1: return m_cnt;
      3'd2: return m_ph ? 32'h5555_5555 : 32'hAAAA_AAAA;
      3'd3: return m_l32;
      3'd4: return m_sh;
      3'd5: return {8'h00, m_l24};
      3'd6: return {5'b0, m_c3, m_c24};
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: sets inputs for the next edge and records what that edge must produce
  task automatic step(input logic [2:0] m, input logic en, input logic rs,
                      input logic [23:0] fw, input string tag);
    item_t it;
    @(posedge clk);
    #2;
    mode = m; enable = en; rand_sel = rs; fixed_word = fw;
    it.p = pick(m);
    it.t = {4'h0, (rs ? m_l24 : fw)};
    it.tag = tag;
    sb.push_back(it);
    if (en) model_step();
  endtask

  task automatic run(input logic [2:0] m, input int n);
    for (int i = 0; i < n; i++) step(m, 1'b1, 1'b1, 24'h0, mode_tag(m));
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      got = sb.pop_front();
      check(got.tag, pattern_out, got.p);
      check("R11", {4'h0, test_word_out}, {4'h0, got.t});
    end
  end

  task automatic do_reset();
    @(posedge clk);
    #3;
    rst_n = 1'b0; enable = 1'b0;
    #1;
    check("R1", pattern_out, 32'h0);
    check("R1", {4'h0, test_word_out}, 32'h0);
    model_reset();
    repeat (2) @(posedge clk);
    #1;
    check("R1", pattern_out, 32'h0);
    #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    rst_n = 1'b1; enable = 1'b0; mode = 3'd0; fixed_word = '0; rand_sel = 1'b0;
    do_reset();

    run(3'd0, 40);
    run(3'd1, 20);
    run(3'd2, 6);
    run(3'd3, 80);
    run(3'd4, 70);
    run(3'd5, 40);
    run(3'd6, 20);
    run(3'd7, 4);

    // R11: fixed word path with the pseudo-random path deselected
    for (int i = 0; i < 8; i++) step(3'd1, 1'b1, 1'b0, 24'hA5_0000 ^ (24'h01_2345 * i), "R11");
    for (int i = 0; i < 3; i++) step(3'd5, 1'b0, 1'b1, 24'hFF_FFFF, "R11");

    // R2: enable low holds every generator, then uneven enable
    for (int i = 0; i < 5; i++) step(3'd1, 1'b0, 1'b1, 24'h0, "R2");
    for (int i = 0; i < 12; i++) step(3'd3, (i % 3) != 0, 1'b1, 24'h0, "R2");
    for (int i = 0; i < 6; i++) step(3'd4, i[0], 1'b0, 24'h12_3456, "R2");

    // R12: mode changes every edge
    for (int i = 0; i < 24; i++) step(3'((i * 5) % 8), 1'b1, i[1], 24'h00_0F0F, "R12");

    // R1: reset mid-run restores seeds
    do_reset();
    step(3'd0, 1'b1, 1'b1, 24'h0, "R1");
    step(3'd4, 1'b1, 1'b1, 24'h0, "R1");
    step(3'd2, 1'b1, 1'b1, 24'h0, "R1");
    step(3'd3, 1'b1, 1'b1, 24'h0, "R1");

    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule